// File: doc/BRIEF.md
# Redundant Timing Gate Generator with Automatic Switchover

This block holds several identical sets of programmable timing gates. Every set runs from the same clock and the same cycle-start pulse. Each gate in a set has a start count and a stop count, loaded through a simple write port. After loading, each set free-runs on every machine cycle and needs no further writes. Each set counts clocks from the most recent cycle start and drives its gates from that count.

A health monitor compares the gate vector of the active set with a partner set on every clock. When the two differ, both sets are marked faulty. At the next cycle start the output moves to the lowest-indexed healthy set, so no gate is cut short in the middle of a cycle. If every set is marked faulty, the gate outputs are forced low and a fatal flag is raised. Rewriting any register of a set clears that set's fault mark, and the set can then be chosen again.

Top module: `redundant_gate_gen`

## Requirements
- R1: After reset, `gate_o` is all zero, `active_o` is 0, `fault_o` is all zero and `fatal_o` is low.
- R2: The count is 0 in the cycle after the clock edge where `cycle_start_i` is sampled high, and rises by one on each clock after that. A gate is high while start <= count < stop. When start >= stop, the gate never goes high.
- R3: Before the first cycle start, every gate is low. The count stops at its maximum value (all ones) and does not wrap. Only a new cycle start brings it back to 0.
- R4: On every clock where the active set is healthy, its gates are compared with the partner set. The partner is the first healthy set found by going upward from the active index, wrapping past the last set. A mismatch sets the fault bits of both sets in `fault_o` (bit i is set i) one cycle later. When no partner exists, nothing is compared.
- R5: `active_o` changes only on a clock edge where `cycle_start_i` is high and the active set is marked faulty. It then moves to the lowest-indexed healthy set. Until that edge, `gate_o` keeps following the old active set.
- R6: While all fault bits are set, `fatal_o` is high and `gate_o` is forced to zero. `active_o` keeps its value.
- R7: A write to a set clears that set's fault bit. The change shows in the cycle after the write. When a fault bit clears, `fatal_o` goes low again.
- R8: A write stores `wr_data_i` into gate `wr_gate_i` of set `wr_set_i`. It goes into the start count when `wr_stop_i` = 0 and into the stop count when `wr_stop_i` = 1. All counts reset to 0.
- R9: Sets that hold identical contents never raise a fault bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cycle_start_i | input | 1 | Machine cycle start pulse |
| wr_en_i | input | 1 | Register write strobe |
| wr_set_i | input | SET_W | Target set of the write |
| wr_gate_i | input | GATE_W | Target gate of the write |
| wr_stop_i | input | 1 | 0 writes the start count, 1 writes the stop count |
| wr_data_i | input | CNT_W | Count value to store |
| gate_o | output | N_GATES | Gate vector of the active set |
| active_o | output | SET_W | Index of the set driving `gate_o` |
| fault_o | output | N_SETS | Fault mark for each set |
| fatal_o | output | 1 | High when every set is marked faulty |

## Verification
The bench builds the block with four sets, four gates and an 8-bit count. With an 8-bit count, saturation at 255 and the absence of wrap-around can be reached in a few hundred cycles. With four gates, the bench can cover at the same time a normal window, a one-count window at count 0, an empty window with start equal to stop, and an inverted window. Staged writes that disturb one set at a time drive the selector through these steps:
- a pairwise mismatch,
- a deferred switchover,
- total failure with the outputs forced low,
- recovery through a rewrite.

// File: rtl/rgg_pkg.sv
package rgg_pkg;
  typedef enum logic {
    FLD_START = 1'b0,
    FLD_STOP  = 1'b1
  } gate_fld_e;
endpackage

// File: rtl/rgg_cycle_cnt.sv
module rgg_cycle_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cycle_start_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             run_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o <= '0;
      run_o <= 1'b0;
    end else if (cycle_start_i) begin
      cnt_o <= '0;
      run_o <= 1'b1;
    end else if (run_o && cnt_o != CNT_MAX) begin
      cnt_o <= cnt_o + 1'b1;
    end
  end

  a_r3_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cycle_start_i |=> (cnt_o == '0) && run_o);
  a_r3_saturate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_o && cnt_o == CNT_MAX && !cycle_start_i) |=> cnt_o == CNT_MAX);
endmodule

// File: rtl/rgg_gate_set.sv
module rgg_gate_set
  import rgg_pkg::*;
#(
  parameter int N_GATES = 8,
  parameter int CNT_W   = 16,
  parameter int GATE_W  = 3
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cycle_start_i,
  input  logic               wr_en_i,
  input  logic [GATE_W-1:0]  wr_gate_i,
  input  logic               wr_stop_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  output logic [N_GATES-1:0] gate_o
);
  logic [CNT_W-1:0] start_q [N_GATES];
  logic [CNT_W-1:0] stop_q  [N_GATES];
  logic [CNT_W-1:0] cnt;
  logic             run;

  rgg_cycle_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cycle_start_i (cycle_start_i),
    .cnt_o         (cnt),
    .run_o         (run)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int g = 0; g < N_GATES; g++) begin
        start_q[g] <= '0;
        stop_q[g]  <= '0;
      end
    end else if (wr_en_i && int'(wr_gate_i) < N_GATES) begin
      if (gate_fld_e'(wr_stop_i) == FLD_STOP) stop_q[wr_gate_i]  <= wr_data_i;
      else                                    start_q[wr_gate_i] <= wr_data_i;
    end
  end

  for (genvar g = 0; g < N_GATES; g++) begin : g_gate
    assign gate_o[g] = run && (cnt >= start_q[g]) && (cnt < stop_q[g]);
  end
endmodule

// File: rtl/rgg_health.sv
module rgg_health #(
  parameter int N_SETS  = 4,
  parameter int N_GATES = 8,
  parameter int SET_W   = 2
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            cycle_start_i,
  input  logic                            wr_en_i,
  input  logic [SET_W-1:0]                wr_set_i,
  input  logic [N_SETS-1:0][N_GATES-1:0]  set_gates_i,
  output logic [SET_W-1:0]                act_o,
  output logic [N_SETS-1:0]               fault_o,
  output logic                            fatal_o
);
  logic [SET_W-1:0]  act_q, partner, spare;
  logic              partner_ok, spare_ok, cmp_en, mismatch;
  logic [N_SETS-1:0] fault_q, fault_d;
  int                idx;

  // partner: first healthy set above the active one, wrapping
  always_comb begin
    partner    = act_q;
    partner_ok = 1'b0;
    idx        = 0;
    for (int k = 1; k < N_SETS; k++) begin
      idx = (int'(act_q) + k) % N_SETS;
      if (!partner_ok && !fault_q[idx]) begin
        partner    = SET_W'(idx);
        partner_ok = 1'b1;
      end
    end
  end

  always_comb begin
    spare    = '0;
    spare_ok = 1'b0;
    for (int s = 0; s < N_SETS; s++) begin
      if (!spare_ok && !fault_q[s]) begin
        spare    = SET_W'(s);
        spare_ok = 1'b1;
      end
    end
  end

  assign cmp_en   = !fault_q[act_q] && partner_ok;
  assign mismatch = set_gates_i[act_q] != set_gates_i[partner];

  always_comb begin
    fault_d = fault_q;
    if (cmp_en && mismatch) begin
      fault_d[act_q]   = 1'b1;
      fault_d[partner] = 1'b1;
    end
    if (wr_en_i && int'(wr_set_i) < N_SETS) fault_d[wr_set_i] = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fault_q <= '0;
      act_q   <= '0;
    end else begin
      fault_q <= fault_d;
      // move only at a cycle boundary so no gate is cut short
      if (cycle_start_i && fault_q[act_q] && spare_ok) act_q <= spare;
    end
  end

  assign act_o   = act_q;
  assign fault_o = fault_q;
  assign fatal_o = &fault_q;

  a_r4_mark_pair: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_en && mismatch && !wr_en_i) |=> fault_q[$past(act_q)] && fault_q[$past(partner)]);
  a_r9_mark_needs_mismatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($countones(fault_q) > $countones($past(fault_q))) |-> $past(cmp_en && mismatch));
  a_r5_switch_at_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(act_q) |-> $past(cycle_start_i) && $past(fault_q[act_q]));
  a_r7_write_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && int'(wr_set_i) < N_SETS) |=> !fault_q[$past(wr_set_i)]);
endmodule

// File: rtl/redundant_gate_gen.sv
module redundant_gate_gen #(
  parameter int N_SETS  = 4,
  parameter int N_GATES = 8,
  parameter int CNT_W   = 16,
  localparam int SET_W  = (N_SETS > 1) ? $clog2(N_SETS) : 1,
  localparam int GATE_W = (N_GATES > 1) ? $clog2(N_GATES) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cycle_start_i,
  input  logic               wr_en_i,
  input  logic [SET_W-1:0]   wr_set_i,
  input  logic [GATE_W-1:0]  wr_gate_i,
  input  logic               wr_stop_i,
  input  logic [CNT_W-1:0]   wr_data_i,
  output logic [N_GATES-1:0] gate_o,
  output logic [SET_W-1:0]   active_o,
  output logic [N_SETS-1:0]  fault_o,
  output logic               fatal_o
);
  logic [N_SETS-1:0][N_GATES-1:0] set_gates;

  for (genvar s = 0; s < N_SETS; s++) begin : g_set
    rgg_gate_set #(.N_GATES(N_GATES), .CNT_W(CNT_W), .GATE_W(GATE_W)) u_set (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .cycle_start_i (cycle_start_i),
      .wr_en_i       (wr_en_i && (int'(wr_set_i) == s)),
      .wr_gate_i     (wr_gate_i),
      .wr_stop_i     (wr_stop_i),
      .wr_data_i     (wr_data_i),
      .gate_o        (set_gates[s])
    );
  end

  rgg_health #(.N_SETS(N_SETS), .N_GATES(N_GATES), .SET_W(SET_W)) u_health (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cycle_start_i (cycle_start_i),
    .wr_en_i       (wr_en_i),
    .wr_set_i      (wr_set_i),
    .set_gates_i   (set_gates),
    .act_o         (active_o),
    .fault_o       (fault_o),
    .fatal_o       (fatal_o)
  );

  assign gate_o = fatal_o ? '0 : set_gates[active_o];

  a_r6_fatal_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (&fault_o) |-> (gate_o == '0) && fatal_o);
  a_r6_active_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(active_o) < N_SETS);
endmodule

// File: tb/redundant_gate_gen_test.sv
module redundant_gate_gen_test;
  localparam int NS = 4, NG = 4, CW = 8;

  logic          clk = 0, rst_n = 0, cs = 0, wr_en = 0, wr_stop = 0;
  logic [1:0]    wr_set = 0, wr_gate = 0;
  logic [CW-1:0] wr_data = 0;
  logic [NG-1:0] gate;
  logic [1:0]    active;
  logic [NS-1:0] fault;
  logic          fatal;

  int n_chk = 0, n_fail = 0;
  int st [NS][NG];
  int sp [NS][NG];
  bit done = 0;

  always #10 clk = ~clk;

  redundant_gate_gen #(.N_SETS(NS), .N_GATES(NG), .CNT_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cycle_start_i(cs), .wr_en_i(wr_en),
    .wr_set_i(wr_set), .wr_gate_i(wr_gate), .wr_stop_i(wr_stop),
    .wr_data_i(wr_data), .gate_o(gate), .active_o(active),
    .fault_o(fault), .fatal_o(fatal));

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int model(int s, int c);
    int cc = (c > 255) ? 255 : c;
    int v = 0;
    for (int g = 0; g < NG; g++)
      if (cc >= st[s][g] && cc < sp[s][g]) v |= (1 << g);
    return v;
  endfunction

  task automatic wr(int s, int g, bit stop, int d);
    wr_en = 1; wr_set = 2'(s); wr_gate = 2'(g); wr_stop = stop; wr_data = CW'(d);
    @(negedge clk);
    wr_en = 0;
    if (stop) sp[s][g] = d; else st[s][g] = d;
  endtask

  task automatic pulse();
    cs = 1;
    @(negedge clk);
    cs = 0;
  endtask

  task automatic t_reset();
    check("R1 gate", int'(gate), 0);
    check("R1 active", int'(active), 0);
    check("R1 fault", int'(fault), 0);
    check("R1 fatal", int'(fatal), 0);
  endtask

  task automatic t_program();
    for (int s = 0; s < NS; s++) begin
      wr(s, 0, 0, 2); wr(s, 0, 1, 5);
      wr(s, 1, 0, 0); wr(s, 1, 1, 1);
      wr(s, 2, 0, 3); wr(s, 2, 1, 3);
      wr(s, 3, 0, 6); wr(s, 3, 1, 4);
    end
    for (int i = 0; i < 4; i++) begin
      check("R3 idle before first start", int'(gate), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_cycle();
    pulse();
    for (int c = 0; c < 12; c++) begin
      check($sformatf("R2/R8 gates c=%0d", c), int'(gate), model(0, c));
      check("R9 equal sets no fault", int'(fault), 0);
      @(negedge clk);
    end
  endtask

  task automatic t_mismatch();
    wr(1, 0, 1, 6);
    pulse();
    for (int c = 0; c < 12; c++) begin
      check($sformatf("R5 old active drives c=%0d", c), int'(gate), model(0, c));
      check("R5 active held", int'(active), 0);
      check($sformatf("R4 marks c=%0d", c), int'(fault), (c >= 6) ? 4'b0011 : 0);
      @(negedge clk);
    end
    pulse();
    check("R5 switch to lowest healthy", int'(active), 2);
    for (int c = 0; c < 12; c++) begin
      check($sformatf("R5 new active gates c=%0d", c), int'(gate), model(2, c));
      check("R4 partner equal", int'(fault), 4'b0011);
      @(negedge clk);
    end
  endtask

  task automatic t_fatal();
    wr(3, 1, 1, 2);
    pulse();
    for (int c = 0; c < 12; c++) begin
      check($sformatf("R6 fatal c=%0d", c), int'(fatal), (c >= 2) ? 1 : 0);
      check($sformatf("R6 gates c=%0d", c), int'(gate), (c >= 2) ? 0 : model(2, c));
      check("R6 active kept", int'(active), 2);
      @(negedge clk);
    end
    pulse();
    repeat (3) @(negedge clk);
    check("R6 forced low at c=3", int'(gate), 0);
    check("R6 no healthy set, active kept", int'(active), 2);
  endtask

  task automatic t_recover();
    wr(0, 0, 1, 5);
    check("R7 fault cleared", int'(fault), 4'b1110);
    check("R7 fatal released", int'(fatal), 0);
    pulse();
    check("R5 recovered set selected", int'(active), 0);
    for (int c = 0; c < 12; c++) begin
      check($sformatf("R7 recovered gates c=%0d", c), int'(gate), model(0, c));
      check("R4 no partner no compare", int'(fault), 4'b1110);
      @(negedge clk);
    end
  endtask

  task automatic t_saturate();
    wr(0, 3, 0, 250); wr(0, 3, 1, 255);
    pulse();
    for (int c = 0; c < 300; c++) begin
      if (c >= 245) check($sformatf("R3 saturate c=%0d", c), int'(gate), model(0, c));
      @(negedge clk);
    end
  endtask

  initial begin
    for (int s = 0; s < NS; s++)
      for (int g = 0; g < NG; g++) begin st[s][g] = 0; sp[s][g] = 0; end
    repeat (2) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_program();
    t_cycle();
    t_mismatch();
    t_fatal();
    t_recover();
    t_saturate();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule